// File: doc/BRIEF.md
# Write-Enable Latch and Status Register Unit

This unit holds the control state of a serial memory. It keeps the write-enable latch, which must be set before any array or status write can finish. It also keeps three protection bits: a protect-enable bit and a two-bit block-protect field. It reports a write-in-progress flag taken directly from the write timer's busy signal. The command decoder sends it single-cycle strobes for enable, disable, status-write completion and array-write completion. The unit returns an 8-bit status byte, which can be read in any cycle, and a write-permit signal for the array.

The protection bits are stored in plain registers. At reset they load a parameter value that stands for their stored contents. The unit does not decode which address range each block-protect setting covers.

Top module: `sr_ctrl`

## Requirements
- R1: `status_o` places protect-enable at bit 7, block-protect high at bit 3, block-protect low at bit 2, the latch at bit 1 and write-in-progress at bit 0. Bits 6 to 4 always read 0.
- R2: Status bit 0 equals `busy_i` in the same cycle, including while a write is in progress.
- R3: While `rst` is high at a clock edge, the latch clears and the protection bits load `PROT_INIT` (default all zero).
- R4: `wren_i` sets the latch at the next edge, whatever the protection bits hold.
- R5: `wrdi_i` clears the latch at the next edge, whatever the protection bits hold.
- R6: A status-write or array-write completion strobe clears the latch at the next edge, provided the latch was set.
- R7: A status-write completion strobe with the latch set loads protect-enable from data bit 7, block-protect high from data bit 3 and block-protect low from data bit 2. The other data bits have no effect.
- R8: A completion strobe with the latch clear is not a successful write. The protection bits stay unchanged and the latch stays clear.
- R9: When `wren_i` arrives in the same cycle as any clearing event from R5 or R6, the clearing event wins and the latch ends clear.
- R10: `write_permit_o` is 1 exactly when the latch is set and `busy_i` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| wren_i | input | 1 | Enable command strobe |
| wrdi_i | input | 1 | Disable command strobe |
| wrsr_done_i | input | 1 | Status-register write completed |
| wr_done_i | input | 1 | Array write completed |
| wrsr_data_i | input | 8 | Data byte of the status write |
| busy_i | input | 1 | Write timer busy |
| status_o | output | 8 | Status byte |
| write_permit_o | output | 1 | Array write allowed |

## Verification
The hardest case to reach is a cycle where several strobes coincide with a given latch state and a given busy level. The bench first drives the latch to a known value. It then applies each of the 16 strobe combinations at both busy levels, and compares the latch, protection bits, flag and permit against an arithmetic model of the priority rules. A separate sweep writes all 256 data bytes through successful status writes, which shows that only bits 7, 3 and 2 are stored.

// File: rtl/wel_stat_pkg.sv
package wel_stat_pkg;
    localparam int STAT_W  = 8;
    localparam int PEN_BIT = 7;
    localparam int BP1_BIT = 3;
    localparam int BP0_BIT = 2;
    localparam int WEL_BIT = 1;
    localparam int WIP_BIT = 0;

    typedef struct packed {
        logic pen;
        logic bp1;
        logic bp0;
    } prot_t;

    typedef struct packed {
        logic wren;
        logic wrdi;
        logic wrsr_done;
        logic wr_done;
    } cmd_t;

    function automatic logic [STAT_W-1:0] pack_status(prot_t p, logic wel, logic wip);
        logic [STAT_W-1:0] s;
        s          = '0;
        s[PEN_BIT] = p.pen;
        s[BP1_BIT] = p.bp1;
        s[BP0_BIT] = p.bp0;
        s[WEL_BIT] = wel;
        s[WIP_BIT] = wip;
        return s;
    endfunction

    function automatic prot_t unpack_prot(logic [STAT_W-1:0] d);
        prot_t p;
        p.pen = d[PEN_BIT];
        p.bp1 = d[BP1_BIT];
        p.bp0 = d[BP0_BIT];
        return p;
    endfunction
endpackage

// File: rtl/enable_latch.sv
module enable_latch
    import wel_stat_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  cmd_t cmd,
    output logic wel
);
    logic clr_ev;

    // clearing events: disable command or a successful completion
    always_comb clr_ev = cmd.wrdi | (wel & (cmd.wrsr_done | cmd.wr_done));

    always_ff @(posedge clk) begin
        if (rst)          wel <= 1'b0;
        else if (clr_ev)  wel <= 1'b0;
        else if (cmd.wren) wel <= 1'b1;
    end

    p_reset_clears_r3: assert property (@(posedge clk) rst |=> !wel);
    p_wren_sets_r4: assert property (@(posedge clk) disable iff (rst)
        (cmd.wren && !cmd.wrdi && !cmd.wrsr_done && !cmd.wr_done) |=> wel);
    p_wrdi_clears_r5: assert property (@(posedge clk) disable iff (rst)
        cmd.wrdi |=> !wel);
    p_done_clears_r6: assert property (@(posedge clk) disable iff (rst)
        (wel && (cmd.wrsr_done || cmd.wr_done)) |=> !wel);
endmodule

// File: rtl/prot_store.sv
module prot_store
    import wel_stat_pkg::*;
#(
    parameter prot_t PROT_INIT = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [STAT_W-1:0] data,
    output prot_t             prot
);
    always_ff @(posedge clk) begin
        if (rst)       prot <= PROT_INIT;
        else if (load) prot <= unpack_prot(data);
    end

    p_reset_init_r3: assert property (@(posedge clk) rst |=> (prot == PROT_INIT));
endmodule

// File: rtl/sr_ctrl.sv
module sr_ctrl
    import wel_stat_pkg::*;
#(
    parameter prot_t PROT_INIT = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wren_i,
    input  logic              wrdi_i,
    input  logic              wrsr_done_i,
    input  logic              wr_done_i,
    input  logic [STAT_W-1:0] wrsr_data_i,
    input  logic              busy_i,
    output logic [STAT_W-1:0] status_o,
    output logic              write_permit_o
);
    cmd_t  cmd;
    logic  wel;
    logic  prot_load;
    prot_t prot;

    always_comb begin
        cmd.wren      = wren_i;
        cmd.wrdi      = wrdi_i;
        cmd.wrsr_done = wrsr_done_i;
        cmd.wr_done   = wr_done_i;
    end

    enable_latch i_latch (.clk(clk), .rst(rst), .cmd(cmd), .wel(wel));

    // a status write only takes effect when the latch was set
    always_comb prot_load = wrsr_done_i & wel;

    prot_store #(.PROT_INIT(PROT_INIT)) i_prot (
        .clk(clk), .rst(rst), .load(prot_load), .data(wrsr_data_i), .prot(prot)
    );

    always_comb status_o       = pack_status(prot, wel, busy_i);
    always_comb write_permit_o = wel & ~busy_i;

    p_unused_zero_r1: assert property (@(posedge clk) disable iff (rst)
        status_o[6:4] == 3'b000);
    p_prot_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !(wrsr_done_i && status_o[WEL_BIT]) |=> $stable(status_o[7:2]));
    p_busy_blocks_r10: assert property (@(posedge clk) disable iff (rst)
        busy_i |-> !write_permit_o);
endmodule

// File: tb/test_sr_ctrl.sv
module test_sr_ctrl;
    logic       clk = 1'b0;
    logic       rst;
    logic       wren, wrdi, wsd, wd, busy;
    logic [7:0] data;
    logic [7:0] status;
    logic       permit;
    int         n_chk = 0;
    int         n_err = 0;
    logic       wel_e;
    logic [2:0] prot_e;

    always #2 clk = ~clk;

    sr_ctrl i_sr_ctrl (
        .clk(clk), .rst(rst), .wren_i(wren), .wrdi_i(wrdi), .wrsr_done_i(wsd),
        .wr_done_i(wd), .wrsr_data_i(data), .busy_i(busy),
        .status_o(status), .write_permit_o(permit)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic idle();
        wren = 0; wrdi = 0; wsd = 0; wd = 0;
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic set_wel(input logic v);
        idle(); wren = v; wrdi = ~v; cyc(); idle();
        wel_e = v;
    endtask

    initial begin
        #400000;
        n_err++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        idle(); busy = 0; data = 8'h00; rst = 1;
        cyc(); cyc();
        rst = 0;
        // R3 reset state
        chk("R3", status, 8'h00);
        chk("R10", {7'd0, permit}, 8'h00);
        wel_e = 0; prot_e = 3'b000;

        // R7: sweep every data byte through successful status writes
        for (int d = 0; d < 256; d++) begin
            set_wel(1'b1);
            data = d[7:0]; wsd = 1; cyc(); idle();
            prot_e = {data[7], data[3], data[2]};
            wel_e = 0;
            chk("R7", status, {prot_e[2], 3'b000, prot_e[1:0], 2'b00});
        end

        // near-exhaustive: latch state x strobe combination x busy
        for (int w = 0; w < 2; w++) begin
            for (int s = 0; s < 16; s++) begin
                for (int b = 0; b < 2; b++) begin
                    logic       clr, nxt;
                    logic [2:0] pn;
                    string      tag;
                    set_wel(w[0]);
                    data = {s[3:0], b[0], 3'b101} ^ 8'h5A;
                    wren = s[0]; wrdi = s[1]; wsd = s[2]; wd = s[3]; busy = b[0];
                    clr = wrdi | (wel_e & (wsd | wd));
                    nxt = clr ? 1'b0 : (wren ? 1'b1 : wel_e);
                    pn  = (wsd & wel_e) ? {data[7], data[3], data[2]} : prot_e;
                    if (clr && wren)             tag = "R9";
                    else if (wrdi)               tag = "R5";
                    else if (wel_e && (wsd||wd)) tag = "R6";
                    else if (wren)               tag = "R4";
                    else                         tag = "R8";
                    cyc();
                    wel_e = nxt;
                    chk(tag, {7'd0, status[1]}, {7'd0, wel_e});
                    chk((wsd && w[0]) ? "R7" : "R8", {5'd0, status[7], status[3:2]}, {5'd0, pn});
                    prot_e = pn;
                    chk("R2", {7'd0, status[0]}, {7'd0, busy});
                    chk("R1", {5'd0, status[6:4]}, 8'h00);
                    chk("R10", {7'd0, permit}, {7'd0, wel_e & ~busy});
                    idle(); busy = 0;
                end
            end
        end

        // R3: reset with latch set and protection bits nonzero
        set_wel(1'b1);
        data = 8'h8C; wsd = 1; cyc(); idle();
        set_wel(1'b1);
        chk("R1", status, 8'h8E);
        rst = 1; cyc(); rst = 0;
        chk("R3", status, 8'h00);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule